// File: doc/BRIEF.md
# Indirect Register Window Access Checker

This block decides whether an access through one of the three indirect register windows should trap. The three windows are machine, supervisor and virtual-supervisor. A window is a CSR whose meaning depends on a companion select register. The block has three inputs for the select registers. It also takes the current privilege and virtualization state, the guest external interrupt number, and a supervisor external interrupt virtualization enable. A per-access request names the window. It produces one verdict code, registered one cycle after the request.

The ordinary CSR checks are computed elsewhere and arrive as two flags: base illegal and base virtual. These checks cover existence, read-only, privilege and state-enable gating. Both flags are resolved before any select-value range is looked at. Because of that order, a virtual-instruction outcome from an enable gate beats an illegal-instruction outcome that a reserved select value would otherwise cause. A request that targets no window simply returns the base verdict.

Top module: `icsr_exc_check`

## Requirements
- R1: During and right after reset, `rsp_valid` is 0 and `rsp_verdict` is 00.
- R2: `rsp_valid` follows `req_valid` with one cycle of latency. The verdict codes are 00 none, 01 illegal instruction and 10 virtual instruction. Code 11 never appears. The verdict is 00 whenever `rsp_valid` is 0.
- R3: When `base_ill` is set, the verdict is 01 for any window and any select value.
- R4: When `base_vi` is set and `base_ill` is clear, the verdict is 10, even if the select value is reserved.
- R5: With window code 00 (no window) and no base flag set, the verdict is 00. Window codes are: 00 none, 01 machine, 10 supervisor, 11 virtual-supervisor.
- R6: The reserved select values are 0x000–0x02F, 0x040–0x06F and everything above 0x0FF. Any of these gives 01 on every window, including the supervisor window while virtualized.
- R7: On the machine window (`msel`), an odd value in 0x030–0x03F gives 01 and an even one gives 00. Values 0x070–0x07F give 00. In 0x080–0x0FF, odd values give 01 and even values give 00.
- R8: The supervisor window without virtualization checks `ssel` by the R7 rules and ignores `vssel`. In addition, values 0x070–0x0FF give 01 when the privilege is supervisor (code 01) and `sext_virt_en` is 1. In machine privilege (code 11) this extra rule does not apply.
- R9: The supervisor window while virtualized (`req_virt`=1) checks `vssel`. Values 0x030–0x03F give 10. In 0x070–0x0FF, the verdict is 10 if the guest number is bad or if the value is above 0x07F and odd; otherwise it is 00.
- R10: The virtual-supervisor window checks `vssel`. Values 0x030–0x03F give 01. In 0x070–0x0FF, a bad guest number or an odd value above 0x07F gives 01; otherwise the verdict is 00. This window never gives 10.
- R11: A guest number is bad when it is 0 or greater than the parameter `GUEST_CNT` (default 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_win | input | 2 | Target window code |
| req_virt | input | 1 | Access made while virtualized |
| cur_priv | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| msel | input | 12 | Machine select register value |
| ssel | input | 12 | Supervisor select register value |
| vssel | input | 12 | Virtual-supervisor select register value |
| guest_num | input | 6 | Guest external interrupt number field |
| sext_virt_en | input | 1 | Supervisor external interrupt virtualization enable |
| base_ill | input | 1 | Base CSR check raised illegal instruction |
| base_vi | input | 1 | Base CSR check raised virtual instruction |
| rsp_valid | output | 1 | Verdict valid |
| rsp_verdict | output | 2 | Verdict code |

## Verification
The block keeps no state across requests, so any internal error shows up in the verdict exactly one cycle after the request that exposes it. Faults come in three kinds: a swapped priority between the base flags and the range checks, a wrong select register picked for a window, and a boundary of a select range placed one value off. Each of these gives a wrong code for specific select values. The directed scenarios therefore probe each range edge (0x02F/0x030, 0x03F/0x040, 0x06F/0x070, 0x07F/0x080, 0x0FF/0x100). They also probe the guest-number limits at 0, at `GUEST_CNT` and at `GUEST_CNT`+1, under every window and virtualization combination.

// File: rtl/icsr_pkg.sv
package icsr_pkg;

    typedef enum logic [1:0] {
        VERD_NONE = 2'b00,
        VERD_ILL  = 2'b01,
        VERD_VI   = 2'b10
    } verdict_e;

    typedef enum logic [1:0] {
        WIN_NONE = 2'b00,
        WIN_MACH = 2'b01,
        WIN_SUP  = 2'b10,
        WIN_VSUP = 2'b11
    } win_e;

    localparam logic [1:0] PRIV_S = 2'b01;

    typedef struct packed {
        logic rsv;     // reserved value
        logic prio;    // 0x30..0x3F
        logic ext;     // 0x70..0xFF
        logic ext_hi;  // 0x80..0xFF
        logic odd;
    } sel_class_t;

    typedef struct packed {
        logic     vld;
        verdict_e verdict;
    } rsp_t;

endpackage

// File: rtl/icsr_sel_class.sv
module icsr_sel_class
    import icsr_pkg::*;
#(
    parameter int SEL_W = 12
) (
    input  logic [SEL_W-1:0] sel,
    output sel_class_t       cls
);
    localparam logic [SEL_W-1:0] PRIO_LO = SEL_W'(12'h030);
    localparam logic [SEL_W-1:0] PRIO_HI = SEL_W'(12'h03F);
    localparam logic [SEL_W-1:0] RSV2_HI = SEL_W'(12'h06F);
    localparam logic [SEL_W-1:0] EXT_LO  = SEL_W'(12'h070);
    localparam logic [SEL_W-1:0] EXTH_LO = SEL_W'(12'h080);
    localparam logic [SEL_W-1:0] EXT_HI  = SEL_W'(12'h0FF);

    always_comb begin
        cls.prio   = (sel >= PRIO_LO) && (sel <= PRIO_HI);
        cls.ext    = (sel >= EXT_LO)  && (sel <= EXT_HI);
        cls.ext_hi = (sel >= EXTH_LO) && (sel <= EXT_HI);
        cls.odd    = sel[0];
        cls.rsv    = (sel < PRIO_LO) || ((sel > PRIO_HI) && (sel <= RSV2_HI)) || (sel > EXT_HI);
    end
endmodule

// File: rtl/icsr_win_rules.sv
module icsr_win_rules
    import icsr_pkg::*;
(
    input  win_e       win,
    input  logic       virt,
    input  logic [1:0] priv,
    input  sel_class_t mcls,
    input  sel_class_t scls,
    input  sel_class_t vcls,
    input  logic       guest_bad,
    input  logic       sext_en,
    output verdict_e   verdict
);
    sel_class_t c;
    logic       odd_hi;
    logic       ext_fault;

    always_comb begin
        unique case (win)
            WIN_MACH: c = mcls;
            WIN_SUP:  c = virt ? vcls : scls;
            default:  c = vcls;
        endcase
        odd_hi    = c.ext_hi && c.odd;
        ext_fault = c.ext && (guest_bad || odd_hi);

        verdict = VERD_NONE;
        unique case (win)
            WIN_MACH: begin
                if (c.rsv || (c.prio && c.odd) || odd_hi) verdict = VERD_ILL;
            end
            WIN_SUP: begin
                if (c.rsv) verdict = VERD_ILL;
                else if (virt) begin
                    if (c.prio || ext_fault) verdict = VERD_VI;
                end else if ((c.prio && c.odd) || odd_hi ||
                             (c.ext && (priv == PRIV_S) && sext_en)) begin
                    verdict = VERD_ILL;
                end
            end
            WIN_VSUP: begin
                if (c.rsv || c.prio || ext_fault) verdict = VERD_ILL;
            end
            default: verdict = VERD_NONE;
        endcase
    end
endmodule

// File: rtl/icsr_exc_check.sv
module icsr_exc_check
    import icsr_pkg::*;
#(
    parameter int SEL_W     = 12,
    parameter int GUEST_W   = 6,
    parameter int GUEST_CNT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_win,
    input  logic               req_virt,
    input  logic [1:0]         cur_priv,
    input  logic [SEL_W-1:0]   msel,
    input  logic [SEL_W-1:0]   ssel,
    input  logic [SEL_W-1:0]   vssel,
    input  logic [GUEST_W-1:0] guest_num,
    input  logic               sext_virt_en,
    input  logic               base_ill,
    input  logic               base_vi,
    output logic               rsp_valid,
    output logic [1:0]         rsp_verdict
);
    localparam int NUM_SEL = 3;
    localparam logic [GUEST_W-1:0] GUEST_LIM = GUEST_W'(GUEST_CNT);

    logic [SEL_W-1:0] sel_arr [NUM_SEL];
    sel_class_t       cls_arr [NUM_SEL];

    assign sel_arr[0] = msel;
    assign sel_arr[1] = ssel;
    assign sel_arr[2] = vssel;

    for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_cls
        icsr_sel_class #(.SEL_W(SEL_W)) u_cls (
            .sel (sel_arr[gi]),
            .cls (cls_arr[gi])
        );
    end

    logic     guest_bad;
    verdict_e ind_verdict;

    assign guest_bad = (guest_num == '0) || (guest_num > GUEST_LIM);

    icsr_win_rules u_rules (
        .win       (win_e'(req_win)),
        .virt      (req_virt),
        .priv      (cur_priv),
        .mcls      (cls_arr[0]),
        .scls      (cls_arr[1]),
        .vcls      (cls_arr[2]),
        .guest_bad (guest_bad),
        .sext_en   (sext_virt_en),
        .verdict   (ind_verdict)
    );

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d.vld     = req_valid;
        rsp_d.verdict = VERD_NONE;
        if (req_valid) begin
            if (base_ill)                      rsp_d.verdict = VERD_ILL;
            else if (base_vi)                  rsp_d.verdict = VERD_VI;
            else if (win_e'(req_win) != WIN_NONE) rsp_d.verdict = ind_verdict;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '{vld: 1'b0, verdict: VERD_NONE};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid   = rsp_q.vld;
    assign rsp_verdict = rsp_q.verdict;

    assert_idle_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_verdict == 2'b00);
    assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_verdict != 2'b11);
    assert_base_ill_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && base_ill |=> rsp_verdict == 2'b01);
    assert_base_vi_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !base_ill && base_vi |=> rsp_verdict == 2'b10);
    assert_no_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !base_ill && !base_vi && req_win == 2'b00 |=> rsp_verdict == 2'b00);
    assert_high_rsv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !base_ill && !base_vi && req_win == 2'b01 && msel > 12'h0FF
        |=> rsp_verdict == 2'b01);
    assert_vsup_no_vi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !base_ill && !base_vi && req_win == 2'b11 |=> rsp_verdict != 2'b10);
endmodule

// File: tb/icsr_exc_check_bench.sv
module icsr_exc_check_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_win = 2'b00;
    logic        req_virt = 1'b0;
    logic [1:0]  cur_priv = 2'b11;
    logic [11:0] msel = '0, ssel = '0, vssel = '0;
    logic [5:0]  guest_num = 6'd1;
    logic        sext_virt_en = 1'b0;
    logic        base_ill = 1'b0, base_vi = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_verdict;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    icsr_exc_check u_icsr_exc_check (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_win(req_win),
        .req_virt(req_virt), .cur_priv(cur_priv), .msel(msel), .ssel(ssel),
        .vssel(vssel), .guest_num(guest_num), .sext_virt_en(sext_virt_en),
        .base_ill(base_ill), .base_vi(base_vi),
        .rsp_valid(rsp_valid), .rsp_verdict(rsp_verdict)
    );

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge, sample the verdict one edge later.
    task automatic access(string req, logic [1:0] win, logic virt, logic [1:0] priv,
                          logic [11:0] m, logic [11:0] s, logic [11:0] v,
                          logic [5:0] g, logic sen, logic bi, logic bv,
                          logic [1:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_win = win; req_virt = virt; cur_priv = priv;
        msel = m; ssel = s; vssel = v; guest_num = g; sext_virt_en = sen;
        base_ill = bi; base_vi = bv;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {1'b0, rsp_valid}, 2'b01);
        check(req, rsp_verdict, exp);
    endtask

    task automatic t_reset();
        check("R1 valid", {1'b0, rsp_valid}, 2'b00);
        check("R1 verdict", rsp_verdict, 2'b00);
    endtask

    task automatic t_idle();
        @(negedge clk);
        check("R2 idle valid", {1'b0, rsp_valid}, 2'b00);
        check("R2 idle verdict", rsp_verdict, 2'b00);
    endtask

    task automatic t_base();
        access("R3 base ill over vi", 2'b10, 1, 2'b01, 0, 0, 12'h034, 1, 0, 1, 1, 2'b01);
        access("R3 base ill legal sel", 2'b01, 0, 2'b11, 12'h030, 0, 0, 1, 0, 1, 0, 2'b01);
        access("R4 base vi over reserved", 2'b10, 1, 2'b01, 0, 0, 12'h045, 1, 0, 0, 1, 2'b10);
        access("R4 base vi machine", 2'b01, 0, 2'b11, 12'h100, 0, 0, 1, 0, 0, 1, 2'b10);
        access("R5 no window", 2'b00, 0, 2'b11, 12'h000, 12'h000, 12'h000, 0, 1, 0, 0, 2'b00);
    endtask

    task automatic t_reserved();
        access("R6 m 0x02F", 2'b01, 0, 2'b11, 12'h02F, 0, 0, 1, 0, 0, 0, 2'b01);
        access("R6 m 0x040", 2'b01, 0, 2'b11, 12'h040, 0, 0, 1, 0, 0, 0, 2'b01);
        access("R6 m 0x06F", 2'b01, 0, 2'b11, 12'h06F, 0, 0, 1, 0, 0, 0, 2'b01);
        access("R6 m 0x100", 2'b01, 0, 2'b11, 12'h100, 0, 0, 1, 0, 0, 0, 2'b01);
        access("R6 s 0x000", 2'b10, 0, 2'b11, 0, 12'h000, 12'h070, 1, 0, 0, 0, 2'b01);
        access("R6 sv 0x045", 2'b10, 1, 2'b01, 0, 12'h070, 12'h045, 1, 0, 0, 0, 2'b01);
        access("R6 sv 0x100", 2'b10, 1, 2'b01, 0, 12'h070, 12'h100, 1, 0, 0, 0, 2'b01);
        access("R6 vs 0x02F", 2'b11, 0, 2'b01, 0, 0, 12'h02F, 1, 0, 0, 0, 2'b01);
    endtask

    task automatic t_machine();
        access("R7 m 0x030", 2'b01, 0, 2'b11, 12'h030, 0, 0, 1, 0, 0, 0, 2'b00);
        access("R7 m 0x03F", 2'b01, 0, 2'b11, 12'h03F, 0, 0, 1, 0, 0, 0, 2'b01);
        access("R7 m 0x07F", 2'b01, 0, 2'b11, 12'h07F, 0, 0, 0, 0, 0, 0, 2'b00);
        access("R7 m 0x081", 2'b01, 0, 2'b11, 12'h081, 0, 0, 1, 0, 0, 0, 2'b01);
        access("R7 m 0x0FE", 2'b01, 0, 2'b11, 12'h0FE, 0, 0, 1, 0, 0, 0, 2'b00);
    endtask

    task automatic t_super();
        access("R8 s 0x033", 2'b10, 0, 2'b11, 0, 12'h033, 12'h030, 1, 0, 0, 0, 2'b01);
        access("R8 s ignores vssel", 2'b10, 0, 2'b11, 0, 12'h032, 12'h000, 1, 0, 0, 0, 2'b00);
        access("R8 s 0x0FF odd", 2'b10, 0, 2'b11, 0, 12'h0FF, 12'h080, 1, 0, 0, 0, 2'b01);
        access("R8 s S+en 0x072", 2'b10, 0, 2'b01, 0, 12'h072, 0, 1, 1, 0, 0, 2'b01);
        access("R8 s M+en 0x072", 2'b10, 0, 2'b11, 0, 12'h072, 0, 1, 1, 0, 0, 2'b00);
        access("R8 s S no en 0x072", 2'b10, 0, 2'b01, 0, 12'h072, 0, 1, 0, 0, 0, 2'b00);
    endtask

    task automatic t_virt_super();
        access("R9 sv 0x034", 2'b10, 1, 2'b01, 0, 12'h034, 12'h034, 3, 0, 0, 0, 2'b10);
        access("R9 R11 sv guest 0", 2'b10, 1, 2'b01, 0, 12'h070, 12'h070, 0, 0, 0, 0, 2'b10);
        access("R9 R11 sv guest 6", 2'b10, 1, 2'b01, 0, 12'h070, 12'h070, 6, 0, 0, 0, 2'b10);
        access("R9 R11 sv guest 5", 2'b10, 1, 2'b01, 0, 12'h070, 12'h070, 5, 0, 0, 0, 2'b00);
        access("R9 sv 0x083", 2'b10, 1, 2'b01, 0, 12'h070, 12'h083, 5, 0, 0, 0, 2'b10);
        access("R9 sv 0x084", 2'b10, 1, 2'b01, 0, 12'h033, 12'h084, 1, 0, 0, 0, 2'b00);
    endtask

    task automatic t_vs_window();
        access("R10 vs 0x034", 2'b11, 0, 2'b01, 0, 0, 12'h034, 1, 0, 0, 0, 2'b01);
        access("R10 R11 vs guest 0", 2'b11, 0, 2'b01, 0, 0, 12'h074, 0, 0, 0, 0, 2'b01);
        access("R10 R11 vs guest 6", 2'b11, 0, 2'b01, 0, 0, 12'h074, 6, 0, 0, 0, 2'b01);
        access("R10 vs guest 3", 2'b11, 0, 2'b01, 0, 0, 12'h074, 3, 0, 0, 0, 2'b00);
        access("R10 vs 0x085", 2'b11, 0, 2'b01, 0, 0, 12'h085, 3, 0, 0, 0, 2'b01);
        access("R10 vs 0x0FE", 2'b11, 0, 2'b01, 0, 0, 12'h0FE, 5, 0, 0, 0, 2'b00);
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle();
        t_base();
        t_idle();
        t_reserved();
        t_machine();
        t_super();
        t_virt_super();
        t_vs_window();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule